// File: doc/BRIEF.md
# Segmented Address Translation Unit

This block turns a 14-bit virtual address into a physical address using a four-entry segment table kept in registers. The upper two address bits pick a segment and the lower twelve bits are the offset within it. Each entry carries a physical base, a length, a valid flag and three permission bits. On an accepted request the block adds the entry's base to the offset, checks the offset against the length and the access kind against the permissions, and returns either the physical address or a fault code.

The table is loaded through a configuration write port that carries a privilege qualifier. A write without privilege leaves the table untouched and raises a one-cycle denial flag. Because the whole table is in registers, an operating system can save and reload it cheaply on a context switch. Two entries may point at the same physical region with different rights, which lets several address spaces share one region.

Top module: `seg_xlate_unit`

## Requirements
- R1: After reset, `rsp_valid` and `cfg_denied` are 0 and every table entry is invalid. Any access then faults with the bound code.
- R2: On success, `rsp_paddr` equals the entry base plus the zero-extended offset. The offset is `req_vaddr[11:0]` and the segment index is `req_vaddr[13:12]`.
- R3: An offset greater than or equal to the entry length gives `rsp_fault`=1, `rsp_fault_code`=2'b01 (bound) and `rsp_paddr`=0.
- R4: An entry whose valid flag is clear always faults with the bound code 2'b01, whatever the offset and access kind.
- R5: Permission bits are {execute, read, write} in bits [2:0]. Access kind 2'b00 (fetch) needs execute, 2'b01 (load) needs read and 2'b10 (store) needs write. Kind 2'b11 is always refused. A refused in-bound access faults with code 2'b10 (permission).
- R6: When an access breaks both the bound and the permission rule, the code reports bound (2'b01).
- R7: `rsp_valid` is high exactly in the cycle after each cycle in which `req_valid` is high. Fault code 2'b00 comes with `rsp_fault`=0.
- R8: A configuration write with `cfg_priv`=1 replaces the addressed entry from the next cycle on. A write with `cfg_priv`=0 changes nothing and sets `cfg_denied` for exactly the following cycle.
- R9: Two entries with the same base and length but different permissions are each checked against their own permissions.
- R10: A request in the same cycle as a privileged write to its segment is translated with the entry contents from before the write.
- R11: A length of 13'h1000 admits every offset up to 12'hFFF. A length of 0 makes every access to that entry fault with the bound code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Table write strobe |
| cfg_priv | input | 1 | Write is issued in privileged mode |
| cfg_idx | input | 2 | Entry to write |
| cfg_base | input | 16 | Physical base address for the entry |
| cfg_len | input | 13 | Segment length in bytes (0 to 4096) |
| cfg_valid | input | 1 | Valid flag for the entry |
| cfg_perm | input | 3 | Permissions {execute, read, write} |
| cfg_denied | output | 1 | One-cycle flag for a refused unprivileged write |
| req_valid | input | 1 | Translation request strobe |
| req_vaddr | input | 14 | Virtual address {segment, offset} |
| req_kind | input | 2 | Access kind: 00 fetch, 01 load, 10 store, 11 reserved |
| rsp_valid | output | 1 | Response valid, one cycle after the request |
| rsp_paddr | output | 16 | Translated physical address, 0 on fault |
| rsp_fault | output | 1 | Access refused |
| rsp_fault_code | output | 2 | 00 none, 01 bound, 10 permission |

## Verification
The hardest case to create from the ports is a request that reaches the lookup in the same edge as a privileged rewrite of its own entry. Only there does the order of table update and response capture become visible. The bench drives both strobes in one cycle, with a new base that differs from the old one. It checks that the response carries the old base and that the next request carries the new one. An unprivileged write is shown to be harmless by translating through the targeted entry right afterwards, and by checking that the denial flag lasts a single cycle.

// File: rtl/seg_xlate_pkg.sv
// Package: shared widths, encodings and the segment entry type for the
// segmented address translation unit. Assumes a power-of-two segment count.
package seg_xlate_pkg;

    localparam int SEG_BITS = 2;
    localparam int OFF_W    = 12;
    localparam int VA_W     = SEG_BITS + OFF_W;
    localparam int PA_W     = 16;
    localparam int LEN_W    = OFF_W + 1;
    localparam int NUM_SEG  = 1 << SEG_BITS;
    localparam int PERM_W   = 3;

    // Bit positions inside the permission field
    localparam int PERM_X = 2;
    localparam int PERM_R = 1;
    localparam int PERM_WR = 0;

    typedef enum logic [1:0] {
        ACC_FETCH = 2'b00,
        ACC_LOAD  = 2'b01,
        ACC_STORE = 2'b10,
        ACC_RSVD  = 2'b11
    } access_e;

    typedef enum logic [1:0] {
        FLT_NONE  = 2'b00,
        FLT_BOUND = 2'b01,
        FLT_PERM  = 2'b10
    } fault_e;

    typedef struct packed {
        logic               valid;
        logic [PERM_W-1:0]  perm;
        logic [PA_W-1:0]    base;
        logic [LEN_W-1:0]   len;
    } seg_entry_t;

endpackage

// File: rtl/seg_table.sv
// Module: segment table register file.
// Holds NUM_SEG entries, each written whole by a privileged write.
// An unprivileged write is dropped and flagged for one cycle.
// The read port is combinational, so a same-cycle write is not visible
// until the next cycle.
// Assumes synchronous active-low reset that clears every entry to invalid.
module seg_table
    import seg_xlate_pkg::*;
#(
    parameter int N_ENT = NUM_SEG,
    localparam int IDX_W = $clog2(N_ENT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_priv,
    input  logic [IDX_W-1:0] wr_idx,
    input  seg_entry_t       wr_entry,
    input  logic [IDX_W-1:0] rd_idx,
    output seg_entry_t       rd_entry,
    output logic             denied
);

    seg_entry_t entry_q [N_ENT];
    logic       wr_ok;

    // Purpose: qualify a write with the privilege flag
    always_comb wr_ok = wr_en & wr_priv;

    for (genvar g = 0; g < N_ENT; g++) begin : g_ent
        // Purpose: store one table entry, cleared to invalid on reset
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                entry_q[g] <= '0;
            end else if (wr_ok && (wr_idx == IDX_W'(g))) begin
                entry_q[g] <= wr_entry;
            end
        end

        // R8: an unprivileged write leaves every entry unchanged
        a_r8_user_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && !wr_priv) |=> $stable(entry_q[g]))
            else $error("unprivileged write changed entry %0d", g);
    end

    // Purpose: flag a refused unprivileged write for one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            denied <= 1'b0;
        end else begin
            denied <= wr_en & ~wr_priv;
        end
    end

    // Purpose: combinational lookup of the addressed entry
    always_comb rd_entry = entry_q[rd_idx];

    // R8: the denial flag follows a refused write
    a_r8_denied_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_priv) |=> denied)
        else $error("denied flag missing");

    // R8: no denial without a refused write
    a_r8_denied_cause: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && !wr_priv) |=> !denied)
        else $error("spurious denied flag");

endmodule

// File: rtl/seg_check.sv
// Module: bound and permission checker for one access.
// Purely combinational. The bound check treats an invalid entry as an
// out-of-bound access. A bound failure takes priority over a permission
// failure in the reported code.
// Assumes the length field is one bit wider than the offset, so that a
// full-size segment can be described.
module seg_check
    import seg_xlate_pkg::*;
#(
    parameter int OW = OFF_W
) (
    input  seg_entry_t    entry,
    input  logic [OW-1:0] offset,
    input  access_e       kind,
    output logic          bound_bad,
    output logic          perm_bad,
    output fault_e        code
);

    logic allowed;

    // Purpose: offset must be strictly below the length of a valid entry
    always_comb bound_bad = ~entry.valid | ({1'b0, offset} >= entry.len);

    // Purpose: pick the permission bit the access kind requires
    always_comb begin
        unique case (kind)
            ACC_FETCH: allowed = entry.perm[PERM_X];
            ACC_LOAD:  allowed = entry.perm[PERM_R];
            ACC_STORE: allowed = entry.perm[PERM_WR];
            default:   allowed = 1'b0;
        endcase
        perm_bad = ~allowed;
    end

    // Purpose: encode the fault with the bound check first
    always_comb begin
        if (bound_bad) begin
            code = FLT_BOUND;
        end else if (perm_bad) begin
            code = FLT_PERM;
        end else begin
            code = FLT_NONE;
        end
    end

endmodule

// File: rtl/seg_addr_gen.sv
// Module: physical address adder.
// Adds the zero-extended offset to the segment base. The segment index
// bits take no part. Wrap-around past the top of the physical space is
// left to the table contents; the adder simply truncates.
module seg_addr_gen #(
    parameter int BW = 16,
    parameter int OW = 12
) (
    input  logic [BW-1:0] base,
    input  logic [OW-1:0] offset,
    output logic [BW-1:0] paddr
);

    // Purpose: base plus offset
    always_comb paddr = base + BW'(offset);

endmodule

// File: rtl/seg_xlate_unit.sv
// Module: segmented address translation unit (top).
// Splits the virtual address into segment index and offset, looks up the
// segment table, checks bound and rights, and registers the result.
// A response appears one cycle after each request. A faulting response
// carries a zero address. Assumes synchronous active-low reset.
module seg_xlate_unit
    import seg_xlate_pkg::*;
#(
    parameter int SB = SEG_BITS,
    parameter int OW = OFF_W,
    parameter int BW = PA_W,
    localparam int VW = SB + OW,
    localparam int LW = OW + 1,
    localparam int NE = 1 << SB
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic          cfg_priv,
    input  logic [SB-1:0] cfg_idx,
    input  logic [BW-1:0] cfg_base,
    input  logic [LW-1:0] cfg_len,
    input  logic          cfg_valid,
    input  logic [2:0]    cfg_perm,
    output logic          cfg_denied,
    input  logic          req_valid,
    input  logic [VW-1:0] req_vaddr,
    input  logic [1:0]    req_kind,
    output logic          rsp_valid,
    output logic [BW-1:0] rsp_paddr,
    output logic          rsp_fault,
    output logic [1:0]    rsp_fault_code
);

    seg_entry_t    wr_entry;
    seg_entry_t    cur_entry;
    logic [SB-1:0] seg_idx;
    logic [OW-1:0] seg_off;
    logic [BW-1:0] sum_addr;
    logic          chk_bound_bad;
    logic          chk_perm_bad;
    fault_e        chk_code;
    access_e       kind_e;

    // Purpose: split the virtual address and type the access kind
    always_comb begin
        seg_idx = req_vaddr[VW-1:OW];
        seg_off = req_vaddr[OW-1:0];
        kind_e  = access_e'(req_kind);
    end

    // Purpose: pack the configuration fields into one entry
    always_comb begin
        wr_entry.valid = cfg_valid;
        wr_entry.perm  = cfg_perm;
        wr_entry.base  = cfg_base;
        wr_entry.len   = cfg_len;
    end

    seg_table #(.N_ENT(NE)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_we),
        .wr_priv  (cfg_priv),
        .wr_idx   (cfg_idx),
        .wr_entry (wr_entry),
        .rd_idx   (seg_idx),
        .rd_entry (cur_entry),
        .denied   (cfg_denied)
    );

    seg_check #(.OW(OW)) u_check (
        .entry     (cur_entry),
        .offset    (seg_off),
        .kind      (kind_e),
        .bound_bad (chk_bound_bad),
        .perm_bad  (chk_perm_bad),
        .code      (chk_code)
    );

    seg_addr_gen #(.BW(BW), .OW(OW)) u_addr (
        .base   (cur_entry.base),
        .offset (seg_off),
        .paddr  (sum_addr)
    );

    // Purpose: register the response, blanking the address on a fault
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid      <= 1'b0;
            rsp_paddr      <= '0;
            rsp_fault      <= 1'b0;
            rsp_fault_code <= FLT_NONE;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                rsp_fault      <= (chk_code != FLT_NONE);
                rsp_fault_code <= chk_code;
                rsp_paddr      <= (chk_code == FLT_NONE) ? sum_addr : '0;
            end else begin
                rsp_fault      <= 1'b0;
                rsp_fault_code <= FLT_NONE;
                rsp_paddr      <= '0;
            end
        end
    end

    // R7: every request gets a response in the next cycle
    a_r7_rsp_after_req: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid)
        else $error("response missing");

    // R7: no response without a request
    a_r7_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid)
        else $error("spurious response");

    // R7: fault flag agrees with the code
    a_r7_fault_matches_code: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault == (rsp_fault_code != FLT_NONE))
        else $error("fault flag and code disagree");

    // R3: a faulting response never carries an address
    a_r3_fault_blanks_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> (rsp_paddr == '0))
        else $error("address on faulting response");

    // R6: a bound failure is reported as bound even if rights also fail
    a_r6_bound_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && chk_bound_bad) |=> (rsp_fault_code == FLT_BOUND))
        else $error("bound failure not reported as bound");

    // R5: an in-bound access without the right reports a permission fault
    a_r5_perm_fault: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !chk_bound_bad && chk_perm_bad) |=> (rsp_fault_code == FLT_PERM))
        else $error("rights failure not reported");

endmodule

// File: tb/seg_xlate_unit_tb_top.sv
`timescale 1ns/100ps
// Bench for the segmented address translation unit: a vector table walked
// by one loop, then directed tests for reset and corner cases.
module seg_xlate_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic        cfg_priv = 1'b0;
    logic [1:0]  cfg_idx = '0;
    logic [15:0] cfg_base = '0;
    logic [12:0] cfg_len = '0;
    logic        cfg_valid = 1'b0;
    logic [2:0]  cfg_perm = '0;
    logic        cfg_denied;
    logic        req_valid = 1'b0;
    logic [13:0] req_vaddr = '0;
    logic [1:0]  req_kind = '0;
    logic        rsp_valid;
    logic [15:0] rsp_paddr;
    logic        rsp_fault;
    logic [1:0]  rsp_fault_code;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    seg_xlate_unit dut_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_priv(cfg_priv), .cfg_idx(cfg_idx),
        .cfg_base(cfg_base), .cfg_len(cfg_len), .cfg_valid(cfg_valid),
        .cfg_perm(cfg_perm), .cfg_denied(cfg_denied),
        .req_valid(req_valid), .req_vaddr(req_vaddr), .req_kind(req_kind),
        .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
        .rsp_fault_code(rsp_fault_code)
    );

    typedef struct packed {
        logic [13:0] va;
        logic [1:0]  kind;
        logic        flt;
        logic [1:0]  code;
        logic [15:0] pa;
    } vec_t;

    localparam int NV = 14;
    // Table: seg0 base 3000 len 800 XR, seg1 base 0200 len 400 RW,
    // seg2 invalid, seg3 base 3000 len 800 R only.
    localparam vec_t VECS [NV] = '{
        '{14'h0123, 2'b00, 1'b0, 2'b00, 16'h3123}, // R2 fetch from code
        '{14'h0123, 2'b01, 1'b0, 2'b00, 16'h3123}, // R2 load from code
        '{14'h0123, 2'b10, 1'b1, 2'b10, 16'h0000}, // R5 store to code
        '{14'h07FF, 2'b00, 1'b0, 2'b00, 16'h37FF}, // R3 last byte inside
        '{14'h0800, 2'b00, 1'b1, 2'b01, 16'h0000}, // R3 first byte outside
        '{14'h0900, 2'b10, 1'b1, 2'b01, 16'h0000}, // R6 bound and rights both fail
        '{14'h13FF, 2'b10, 1'b0, 2'b00, 16'h05FF}, // R2 store to data
        '{14'h1010, 2'b01, 1'b0, 2'b00, 16'h0210}, // R2 load from data
        '{14'h1010, 2'b00, 1'b1, 2'b10, 16'h0000}, // R5 fetch from data
        '{14'h1400, 2'b01, 1'b1, 2'b01, 16'h0000}, // R3 data past end
        '{14'h2000, 2'b01, 1'b1, 2'b01, 16'h0000}, // R4 invalid entry
        '{14'h3123, 2'b01, 1'b0, 2'b00, 16'h3123}, // R9 shared region read
        '{14'h3123, 2'b00, 1'b1, 2'b10, 16'h0000}, // R9 shared region no execute
        '{14'h1010, 2'b11, 1'b1, 2'b10, 16'h0000}  // R5 reserved kind
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Called at a falling edge; write is applied at the next rising edge
    task automatic cfg_write(input logic priv, input logic [1:0] idx, input logic [15:0] base,
                             input logic [12:0] len, input logic vld, input logic [2:0] perm);
        cfg_we = 1'b1; cfg_priv = priv; cfg_idx = idx; cfg_base = base;
        cfg_len = len; cfg_valid = vld; cfg_perm = perm;
        @(negedge clk);
        cfg_we = 1'b0; cfg_priv = 1'b0;
    endtask

    // Issue one request and sample the response at the following falling edge
    task automatic access(input logic [13:0] va, input logic [1:0] kind);
        req_valid = 1'b1; req_vaddr = va; req_kind = kind;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic expect_rsp(input string tag, input logic flt, input logic [1:0] code,
                              input logic [15:0] pa);
        chk({tag, " valid"}, 32'(rsp_valid), 32'd1);
        chk({tag, " fault"}, 32'(rsp_fault), 32'(flt));
        chk({tag, " code"},  32'(rsp_fault_code), 32'(code));
        chk({tag, " paddr"}, 32'(rsp_paddr), 32'(pa));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk("R1 rsp_valid after reset", 32'(rsp_valid), 32'd0);
        chk("R1 cfg_denied after reset", 32'(cfg_denied), 32'd0);
        access(14'h1010, 2'b01);
        expect_rsp("R1 empty table faults", 1'b1, 2'b01, 16'h0);
        // R7: idle cycle gives no response
        @(negedge clk);
        chk("R7 no response when idle", 32'(rsp_valid), 32'd0);

        // R8: privileged writes fill the table
        cfg_write(1'b1, 2'd0, 16'h3000, 13'h0800, 1'b1, 3'b110);
        cfg_write(1'b1, 2'd1, 16'h0200, 13'h0400, 1'b1, 3'b011);
        cfg_write(1'b1, 2'd3, 16'h3000, 13'h0800, 1'b1, 3'b010);

        // Vector walk: R2 R3 R5 R6 R9, back to back for R7
        for (int i = 0; i < NV; i++) begin
            access(VECS[i].va, VECS[i].kind);
            checks++;
            if (rsp_valid !== 1'b1 || rsp_fault !== VECS[i].flt ||
                rsp_fault_code !== VECS[i].code || rsp_paddr !== VECS[i].pa) begin
                errors++;
                $display("FAIL vector %0d (R2/R3/R5/R6/R9 table): actual v%0b f%0b c%0h pa %0h expected f%0b c%0h pa %0h",
                         i, rsp_valid, rsp_fault, rsp_fault_code, rsp_paddr,
                         VECS[i].flt, VECS[i].code, VECS[i].pa);
            end
        end

        // R8: unprivileged write is ignored and flagged for one cycle
        cfg_write(1'b0, 2'd1, 16'h7000, 13'h0010, 1'b1, 3'b000);
        chk("R8 denied flag set", 32'(cfg_denied), 32'd1);
        access(14'h1010, 2'b01);
        chk("R8 denied flag cleared", 32'(cfg_denied), 32'd0);
        expect_rsp("R8 entry unchanged", 1'b0, 2'b00, 16'h0210);

        // R10: write and request in the same cycle
        cfg_we = 1'b1; cfg_priv = 1'b1; cfg_idx = 2'd1; cfg_base = 16'h0A00;
        cfg_len = 13'h0400; cfg_valid = 1'b1; cfg_perm = 3'b011;
        req_valid = 1'b1; req_vaddr = 14'h1010; req_kind = 2'b01;
        @(negedge clk);
        cfg_we = 1'b0; cfg_priv = 1'b0; req_valid = 1'b0;
        expect_rsp("R10 old contents used", 1'b0, 2'b00, 16'h0210);
        chk("R10 privileged write not flagged", 32'(cfg_denied), 32'd0);
        access(14'h1010, 2'b01);
        expect_rsp("R10 new contents next", 1'b0, 2'b00, 16'h0A10);

        // R11: full-size segment and empty segment
        cfg_write(1'b1, 2'd2, 16'hF000, 13'h1000, 1'b1, 3'b111);
        access(14'h2FFF, 2'b10);
        expect_rsp("R11 full length top offset", 1'b0, 2'b00, 16'hFFFF);
        cfg_write(1'b1, 2'd2, 16'hF000, 13'h0000, 1'b1, 3'b111);
        access(14'h2000, 2'b01);
        expect_rsp("R11 zero length", 1'b1, 2'b01, 16'h0);

        // R4: clearing the valid flag makes a good access fault as bound
        cfg_write(1'b1, 2'd1, 16'h0A00, 13'h0400, 1'b0, 3'b111);
        access(14'h1010, 2'b01);
        expect_rsp("R4 invalidated entry", 1'b1, 2'b01, 16'h0);

        // R9: shared entry 0 still executes after entry 3 tests
        access(14'h0123, 2'b00);
        expect_rsp("R9 code side keeps execute", 1'b0, 2'b00, 16'h3123);

        // R7: response drops after the last request
        @(negedge clk);
        chk("R7 response ends", 32'(rsp_valid), 32'd0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule